// File: doc/BRIEF.md
# Compressed Instruction Expander

This block turns one 16-bit compressed instruction word into the 32-bit base-format instruction that does the same work. It also raises an illegal flag for encodings that it does not support or that are reserved. It sits after fetch alignment in a decode pipeline. The caller presents a halfword with a valid strobe. One clock later the block returns the expanded word, a valid bit and the illegal flag.

The supported forms fall into two groups. Quadrant 0 gives the stack-pointer-relative add, word loads and stores, and, when XLEN is 64, doubleword loads and stores. Quadrant 1 gives the forms that use the 3-bit compact register fields: the two right shifts, AND-immediate, the register-register group (including the 32-bit W forms) and the two branches that compare a register with zero. A 3-bit compact register field `f` always names register `{2'b01, f}`, which is x8 through x15.

The XLEN parameter (32 or 64) decides which encodings are reserved. Floating-point forms, 128-bit forms, quadrant 2 and the remaining funct3 values are all reported as illegal.

Top module: `cinst_expand`

## Requirements
- R1: While reset is held and after it is released, `out_valid`, `out_illegal` and `out_word` read 0 until the first accepted input.
- R2: `out_valid` equals `in_valid` delayed by one clock. When `in_valid` is low, `out_word` and `out_illegal` keep their previous values.
- R3: Quadrant 0 with funct3=000 expands to `addi rd, x2, imm`. Here rd is `{2'b01, bits[4:2]}`. The immediate is zero-extended and built as imm[5:4]=bits[12:11], imm[9:6]=bits[10:7], imm[3]=bit 5 and imm[2]=bit 6. A zero immediate is illegal, and so is the all-zero halfword.
- R4: Quadrant 0 funct3=010 expands to `lw` and funct3=110 expands to `sw`. The base register is `{2'b01, bits[9:7]}` and the data register is `{2'b01, bits[4:2]}`. The zero-extended offset takes offset[5:3] from bits[12:10], offset[2] from bit 6 and offset[6] from bit 5.
- R5: Quadrant 0 funct3=011 expands to `ld` and funct3=111 expands to `sd` when XLEN=64. The offset takes offset[5:3] from bits[12:10] and offset[7:6] from bits[6:5]. When XLEN=32 both encodings are illegal.
- R6: Quadrant 1 funct3=100 with bits[11:10]=00 expands to `srli rd, rd, sh` and with bits[11:10]=01 expands to `srai rd, rd, sh`. Here rd is `{2'b01, bits[9:7]}` and sh is {bit 12, bits[6:2]}. When XLEN=32, bit 12 set makes the form illegal. A shift amount of 0 is legal.
- R7: Quadrant 1 funct3=100 with bits[11:10]=10 expands to `andi rd, rd, imm`. The immediate is the 6-bit value {bit 12, bits[6:2]}, sign-extended.
- R8: Quadrant 1 funct3=100 with bits[11:10]=11 expands into the R-type group, with rs2 = `{2'b01, bits[4:2]}`. With bit 12 = 0, bits[6:5] = 00/01/10/11 select sub/xor/or/and. With bit 12 = 1, 00 selects subw and 01 selects addw, both legal only when XLEN=64. Codes 10 and 11 with bit 12 = 1 are illegal.
- R9: Quadrant 1 funct3=110 expands to `beq rs1, x0, off` and funct3=111 expands to `bne rs1, x0, off`. The offset is sign-extended from offset[8] (bit 12), and the other fields map as offset[4:3]=bits[11:10], offset[7:6]=bits[6:5], offset[2:1]=bits[4:3] and offset[5]=bit 2.
- R10: An input whose low two bits are 11 is returned as `{16'h0000, in_word}` with `out_illegal` low.
- R11: Quadrant 2 and every encoding not listed above is illegal. Whenever `out_illegal` is high, `out_word` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_word` |
| in_word | input | 16 | Compressed instruction halfword |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| out_word | output | 32 | Expanded base instruction, or 0 when illegal |
| out_illegal | output | 1 | Input is unsupported or reserved |

## Verification
The clocked properties assume that `in_word` holds a known value in every cycle where `in_valid` is high, and that the inputs change only between clock edges. They also assume reset is applied before the first transfer. The stimulus is driven on the falling edge from fully defined values and is issued back to back. After a short set of hand-computed cases it walks every one of the 65536 halfwords through a 64-bit instance and a 32-bit instance in parallel. Because of this, each property's antecedent is met many times, both for legal and reserved encodings of every quadrant.

// File: rtl/cx_pkg.sv
package cx_pkg;

   localparam logic [6:0] OPC_LOAD   = 7'b0000011;
   localparam logic [6:0] OPC_STORE  = 7'b0100011;
   localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
   localparam logic [6:0] OPC_OP     = 7'b0110011;
   localparam logic [6:0] OPC_OP32   = 7'b0111011;
   localparam logic [6:0] OPC_BRANCH = 7'b1100011;

   localparam logic [4:0] REG_SP     = 5'd2;
   localparam logic [4:0] REG_ZERO   = 5'd0;

   typedef enum logic [1:0] {
      QD_ZERO = 2'b00,
      QD_ONE  = 2'b01,
      QD_TWO  = 2'b10,
      QD_FULL = 2'b11
   } quad_e;

   typedef struct packed {
      logic        ill;
      logic [31:0] word;
   } cx_result_t;

   // compact 3-bit register field -> x8..x15
   function automatic logic [4:0] cpt_reg(input logic [2:0] f);
      return {2'b01, f};
   endfunction

   function automatic logic [31:0] mk_i(input logic [11:0] imm, input logic [4:0] rs1,
                                        input logic [2:0] f3, input logic [4:0] rd,
                                        input logic [6:0] opc);
      return {imm, rs1, f3, rd, opc};
   endfunction

   function automatic logic [31:0] mk_s(input logic [11:0] imm, input logic [4:0] rs2,
                                        input logic [4:0] rs1, input logic [2:0] f3,
                                        input logic [6:0] opc);
      return {imm[11:5], rs2, rs1, f3, imm[4:0], opc};
   endfunction

   function automatic logic [31:0] mk_r(input logic [6:0] f7, input logic [4:0] rs2,
                                        input logic [4:0] rs1, input logic [2:0] f3,
                                        input logic [4:0] rd, input logic [6:0] opc);
      return {f7, rs2, rs1, f3, rd, opc};
   endfunction

   // imm holds offset bits [12:1]; bit 0 is always zero
   function automatic logic [31:0] mk_b(input logic [12:1] imm, input logic [4:0] rs2,
                                        input logic [4:0] rs1, input logic [2:0] f3);
      return {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], OPC_BRANCH};
   endfunction

endpackage

// File: rtl/cx_q0_dec.sv
module cx_q0_dec
   import cx_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [15:0] hw,
   output cx_result_t  res
);

   logic [2:0]  f3;
   logic [4:0]  rd_lo;
   logic [4:0]  rs_hi;
   logic [9:2]  nz;
   logic [11:0] sp_imm;
   logic [11:0] w_imm;
   logic [31:0] dw_ld_word;
   logic [31:0] dw_st_word;
   logic        dw_ok;
   logic        unused_bits;

   assign unused_bits = ^hw[1:0];
   assign f3     = hw[15:13];
   assign rd_lo  = cpt_reg(hw[4:2]);
   assign rs_hi  = cpt_reg(hw[9:7]);
   assign nz     = {hw[10:7], hw[12:11], hw[5], hw[6]};
   assign sp_imm = {2'b00, nz, 2'b00};
   assign w_imm  = {5'b00000, hw[5], hw[12:10], hw[6], 2'b00};

   generate
      if (XLEN == 64) begin : g_dword
         logic [11:0] d_imm;
         assign d_imm      = {4'b0000, hw[6:5], hw[12:10], 3'b000};
         assign dw_ld_word = mk_i(d_imm, rs_hi, 3'b011, rd_lo, OPC_LOAD);
         assign dw_st_word = mk_s(d_imm, rd_lo, rs_hi, 3'b011, OPC_STORE);
         assign dw_ok      = 1'b1;
      end else begin : g_no_dword
         assign dw_ld_word = '0;
         assign dw_st_word = '0;
         assign dw_ok      = 1'b0;
      end
   endgenerate

   always_comb begin
      res.ill  = 1'b0;
      res.word = '0;
      case (f3)
         3'b000: begin
            res.word = mk_i(sp_imm, REG_SP, 3'b000, rd_lo, OPC_OPIMM);
            res.ill  = (nz == '0);
         end
         3'b010: res.word = mk_i(w_imm, rs_hi, 3'b010, rd_lo, OPC_LOAD);
         3'b110: res.word = mk_s(w_imm, rd_lo, rs_hi, 3'b010, OPC_STORE);
         3'b011: begin
            res.word = dw_ld_word;
            res.ill  = !dw_ok;
         end
         3'b111: begin
            res.word = dw_st_word;
            res.ill  = !dw_ok;
         end
         default: res.ill = 1'b1;
      endcase
   end

endmodule

// File: rtl/cx_q1_dec.sv
module cx_q1_dec
   import cx_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [15:0] hw,
   output cx_result_t  res
);

   logic [2:0]  f3;
   logic [1:0]  sub;
   logic [1:0]  f2;
   logic [4:0]  rd_hi;
   logic [4:0]  rs2_lo;
   logic [5:0]  shamt;
   logic [11:0] sh_imm;
   logic [11:0] and_imm;
   logic [12:1] br_off;
   logic [2:0]  alu_f3;
   logic [6:0]  alu_f7;
   logic        wide_ok;
   logic        unused_bits;

   assign unused_bits = ^hw[1:0];
   assign f3      = hw[15:13];
   assign sub     = hw[11:10];
   assign f2      = hw[6:5];
   assign rd_hi   = cpt_reg(hw[9:7]);
   assign rs2_lo  = cpt_reg(hw[4:2]);
   assign shamt   = {hw[12], hw[6:2]};
   // bit 10 of the immediate separates arithmetic from logical shift
   assign sh_imm  = {1'b0, hw[10], 4'b0000, shamt};
   assign and_imm = {{6{hw[12]}}, hw[12], hw[6:2]};
   assign br_off  = {{4{hw[12]}}, hw[12], hw[6:5], hw[2], hw[11:10], hw[4:3]};
   assign alu_f7  = (f2 == 2'b00) ? 7'b0100000 : 7'b0000000;

   generate
      if (XLEN == 64) begin : g_wide
         assign wide_ok = 1'b1;
      end else begin : g_narrow
         assign wide_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      case (f2)
         2'b00:   alu_f3 = 3'b000;
         2'b01:   alu_f3 = 3'b100;
         2'b10:   alu_f3 = 3'b110;
         default: alu_f3 = 3'b111;
      endcase
   end

   always_comb begin
      res.ill  = 1'b0;
      res.word = '0;
      case (f3)
         3'b100: begin
            case (sub)
               2'b00, 2'b01: begin
                  res.word = mk_i(sh_imm, rd_hi, 3'b101, rd_hi, OPC_OPIMM);
                  res.ill  = hw[12] && !wide_ok;
               end
               2'b10: res.word = mk_i(and_imm, rd_hi, 3'b111, rd_hi, OPC_OPIMM);
               default: begin
                  if (!hw[12]) begin
                     res.word = mk_r(alu_f7, rs2_lo, rd_hi, alu_f3, rd_hi, OPC_OP);
                  end else begin
                     res.word = mk_r(alu_f7, rs2_lo, rd_hi, 3'b000, rd_hi, OPC_OP32);
                     res.ill  = f2[1] || !wide_ok;
                  end
               end
            endcase
         end
         3'b110, 3'b111: res.word = mk_b(br_off, REG_ZERO, rd_hi, {2'b00, hw[13]});
         default: res.ill = 1'b1;
      endcase
   end

endmodule

// File: rtl/cinst_expand.sv
module cinst_expand
   import cx_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic [15:0] in_word,
   output logic        out_valid,
   output logic [31:0] out_word,
   output logic        out_illegal
);

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("cinst_expand: XLEN must be 32 or 64");
      end
   endgenerate

   cx_result_t q0_res;
   cx_result_t q1_res;
   cx_result_t sel_res;
   quad_e      quad;

   assign quad = quad_e'(in_word[1:0]);

   cx_q0_dec #(.XLEN(XLEN)) u_q0 (.hw(in_word), .res(q0_res));
   cx_q1_dec #(.XLEN(XLEN)) u_q1 (.hw(in_word), .res(q1_res));

   always_comb begin
      case (quad)
         QD_ZERO: sel_res = q0_res;
         QD_ONE:  sel_res = q1_res;
         QD_TWO: begin
            sel_res.ill  = 1'b1;
            sel_res.word = '0;
         end
         default: begin
            sel_res.ill  = 1'b0;
            sel_res.word = {16'h0000, in_word};
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_word    <= '0;
         out_illegal <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_illegal <= sel_res.ill;
            out_word    <= sel_res.ill ? '0 : sel_res.word;
         end
      end
   end

   a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_word) && $stable(out_illegal)));
   a_r3_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_word == 16'h0000) |=> out_illegal);
   a_r9_branch_shape: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_word[1:0] == 2'b01 && in_word[15:14] == 2'b11)
      |=> (!out_illegal && out_word[6:0] == OPC_BRANCH && out_word[24:20] == REG_ZERO));
   a_r10_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_word[1:0] == 2'b11)
      |=> (!out_illegal && out_word == {16'h0000, $past(in_word)}));
   a_r11_quad_two: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_word[1:0] == 2'b10) |=> (out_illegal && out_word == '0));
   a_r11_zero_when_bad: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> (out_word == '0));

   generate
      if (XLEN == 32) begin : g_chk_narrow
         a_r5_no_dword: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_word[1:0] == 2'b00 && in_word[14:13] == 2'b11) |=> out_illegal);
         a_r8_no_wform: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_word[1:0] == 2'b01 && in_word[15:10] == 6'b100111) |=> out_illegal);
      end
   endgenerate

endmodule

// File: tb/cinst_expand_tb_top.sv
`timescale 1ns/1ps
module cinst_expand_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_word = 16'h0000;
   logic        ov64, il64, ov32, il32;
   logic [31:0] ow64, ow32;

   int checks = 0;
   int errors = 0;

   // entry: {input halfword, illegal, word}
   logic [48:0] q64[$];
   logic [48:0] q32[$];

   localparam logic [32:0] ILL = {1'b1, 32'h0};

   cinst_expand #(.XLEN(64)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
      .out_valid(ov64), .out_word(ow64), .out_illegal(il64));

   cinst_expand #(.XLEN(32)) dut32_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
      .out_valid(ov32), .out_word(ow32), .out_illegal(il32));

   always #2.5 clk = ~clk;

   function automatic logic [31:0] fi(int imm, int rs1, int f3, int rd, int opc);
      return 32'(((imm & 32'hfff) << 20) | (rs1 << 15) | (f3 << 12) | (rd << 7) | opc);
   endfunction

   function automatic logic [31:0] fs(int imm, int rs2, int rs1, int f3, int opc);
      return 32'((((imm >> 5) & 32'h7f) << 25) | (rs2 << 20) | (rs1 << 15) | (f3 << 12)
                 | ((imm & 32'h1f) << 7) | opc);
   endfunction

   function automatic logic [31:0] fr(int f7, int rs2, int rs1, int f3, int rd, int opc);
      return 32'((f7 << 25) | (rs2 << 20) | (rs1 << 15) | (f3 << 12) | (rd << 7) | opc);
   endfunction

   function automatic logic [31:0] fb(int imm, int rs1, int f3);
      return 32'((((imm >> 12) & 1) << 31) | (((imm >> 5) & 32'h3f) << 25) | (rs1 << 15)
                 | (f3 << 12) | (((imm >> 1) & 32'hf) << 8) | (((imm >> 11) & 1) << 7) | 32'h63);
   endfunction

   // independent reference decoder, returns {illegal, word}
   function automatic logic [32:0] ref_model(logic [15:0] c, bit wide);
      int f3, hi, lo, v, op2;
      f3 = int'(c[15:13]);
      hi = 8 + int'(c[9:7]);
      lo = 8 + int'(c[4:2]);
      case (c[1:0])
         2'b11: return {1'b0, 16'h0000, c};
         2'b10: return ILL;
         2'b00: begin
            case (f3)
               0: begin
                  v = int'(c[6]) * 4 + int'(c[5]) * 8 + int'(c[11]) * 16 + int'(c[12]) * 32
                      + int'(c[10:7]) * 64;
                  if (v == 0) return ILL;
                  return {1'b0, fi(v, 2, 0, lo, 'h13)};
               end
               2, 6: begin
                  v = int'(c[6]) * 4 + int'(c[12:10]) * 8 + int'(c[5]) * 64;
                  if (f3 == 2) return {1'b0, fi(v, hi, 2, lo, 'h03)};
                  return {1'b0, fs(v, lo, hi, 2, 'h23)};
               end
               3, 7: begin
                  if (!wide) return ILL;
                  v = int'(c[12:10]) * 8 + int'(c[6:5]) * 64;
                  if (f3 == 3) return {1'b0, fi(v, hi, 3, lo, 'h03)};
                  return {1'b0, fs(v, lo, hi, 3, 'h23)};
               end
               default: return ILL;
            endcase
         end
         default: begin
            if (f3 == 6 || f3 == 7) begin
               v = int'(c[4:3]) * 2 + int'(c[11:10]) * 8 + int'(c[2]) * 32 + int'(c[6:5]) * 64;
               if (c[12]) v = v - 256;
               return {1'b0, fb(v, hi, f3 - 6)};
            end
            if (f3 != 4) return ILL;
            case (c[11:10])
               2'b00, 2'b01: begin
                  if (!wide && c[12]) return ILL;
                  v = int'(c[12]) * 32 + int'(c[6:2]);
                  if (c[10]) v = v + 'h400;
                  return {1'b0, fi(v, hi, 5, hi, 'h13)};
               end
               2'b10: begin
                  v = int'(c[6:2]);
                  if (c[12]) v = v - 32;
                  return {1'b0, fi(v, hi, 7, hi, 'h13)};
               end
               default: begin
                  op2 = int'(c[6:5]);
                  if (!c[12]) begin
                     case (op2)
                        0: return {1'b0, fr('h20, lo, hi, 0, hi, 'h33)};
                        1: return {1'b0, fr(0, lo, hi, 4, hi, 'h33)};
                        2: return {1'b0, fr(0, lo, hi, 6, hi, 'h33)};
                        default: return {1'b0, fr(0, lo, hi, 7, hi, 'h33)};
                     endcase
                  end
                  if (op2 >= 2 || !wide) return ILL;
                  return {1'b0, fr(op2 == 0 ? 'h20 : 0, lo, hi, 0, hi, 'h3b)};
               end
            endcase
         end
      endcase
   endfunction

   function automatic string tag_of(logic [15:0] c);
      case (c[1:0])
         2'b11: return "R10";
         2'b10: return "R11";
         2'b00: begin
            case (c[15:13])
               3'd0:       return "R3";
               3'd2, 3'd6: return "R4";
               3'd3, 3'd7: return "R5";
               default:    return "R11";
            endcase
         end
         default: begin
            if (c[15:14] == 2'b11) return "R9";
            if (c[15:13] != 3'd4) return "R11";
            case (c[11:10])
               2'b10:   return "R7";
               2'b11:   return "R8";
               default: return "R6";
            endcase
         end
      endcase
   endfunction

   task automatic chk(string tag, logic [32:0] act, logic [32:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b/%08h expected %0b/%08h", tag, act[32], act[31:0],
                  exp[32], exp[31:0]);
      end
   endtask

   task automatic drive(logic [15:0] w);
      in_valid = 1'b1;
      in_word  = w;
      q64.push_back({w, ref_model(w, 1'b1)});
      q32.push_back({w, ref_model(w, 1'b0)});
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic dchk(string tag, logic [15:0] w, logic [32:0] e64, logic [32:0] e32);
      drive(w);
      chk(tag, {il64, ow64}, e64);
      chk(tag, {il32, ow32}, e32);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (ov64) begin
            if (q64.size() == 0) begin
               checks++; errors++;
               $display("FAIL R2: actual output with empty queue expected none (xlen64)");
            end else begin
               logic [48:0] e;
               e = q64.pop_front();
               chk(tag_of(e[48:33]), {il64, ow64}, e[32:0]);
            end
         end
         if (ov32) begin
            if (q32.size() == 0) begin
               checks++; errors++;
               $display("FAIL R2: actual output with empty queue expected none (xlen32)");
            end else begin
               logic [48:0] e;
               e = q32.pop_front();
               chk(tag_of(e[48:33]), {il32, ow32}, e[32:0]);
            end
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", {ov64 | il64, ow64}, 33'h0);
      chk("R1", {ov32 | il32, ow32}, 33'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", {ov64 | il64, ow64}, 33'h0);

      dchk("R3",  16'h0040, {1'b0, 32'h00410413}, {1'b0, 32'h00410413});
      dchk("R3",  16'h0000, ILL, ILL);
      dchk("R10", 16'h0013, {1'b0, 32'h00000013}, {1'b0, 32'h00000013});
      dchk("R6",  16'h8401, {1'b0, 32'h40045413}, {1'b0, 32'h40045413});
      dchk("R6",  16'h9001, {1'b0, 32'h02045413}, ILL);
      dchk("R7",  16'h987D, {1'b0, 32'hFFF47413}, {1'b0, 32'hFFF47413});
      dchk("R8",  16'h9C21, {1'b0, 32'h0084043B}, ILL);
      dchk("R9",  16'hDC7D, {1'b0, 32'hFE040FE3}, {1'b0, 32'hFE040FE3});
      dchk("R5",  16'h6000, {1'b0, 32'h00043403}, ILL);
      dchk("R11", 16'h0002, ILL, ILL);
      dchk("R4",  16'h4044, {1'b0, 32'h00442483}, {1'b0, 32'h00442483});

      // R2: idle input must not disturb held outputs
      in_word = 16'hFFFF;
      @(negedge clk);
      @(negedge clk);
      chk("R2", {ov64, ow64}, {1'b0, 32'h00442483});
      chk("R2", {ov32 | il32, ow32}, {1'b0, 32'h00442483});

      // exhaustive sweep, back to back
      for (int i = 0; i < 65536; i++) drive(16'(i));
      @(negedge clk);
      @(negedge clk);
      chk("R2", {1'b0, 32'(q64.size() + q32.size())}, 33'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++; errors++;
      $display("FAIL R2: watchdog actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule